// File: doc/BRIEF.md
# Segmented Coefficient Address Sequencer

This block produces read addresses for a coefficient memory that holds two coefficient sets in two separate regions of one address space. Set A lives in the lower region, starting at address 0. Set B lives in the upper region, starting at address `SET_LEN`. With the defaults, the space has 60 locations behind a 6-bit address. Each set keeps its own pointer. A select input chooses the set that is read. On every enabled clock, the selected pointer's current value is registered onto the address output and the pointer then steps once, up or down. A pointer never leaves its own region: it wraps from one end of the region to the other.

A small controller sits at the centre. Its states are `SEQ_IDLE` (no address presented this cycle), `SEQ_EMIT_A` (a set-A address presented) and `SEQ_EMIT_B` (a set-B address presented). It moves from any state to `SEQ_EMIT_A` when `en`=1 and `set_sel`=0. It moves from any state to `SEQ_EMIT_B` when `en`=1 and `set_sel`=1. It moves from any state to `SEQ_IDLE` when `en`=0. The state about to be entered decides which pointer steps and what the output registers load. The unselected pointer keeps its position, so a set resumes exactly where it stopped. Reads are sequential only: there is no random-access address input.

Top module: `coef_addr_seq`

## Requirements
- R1: Asynchronous active-high `rst` clears `addr` to 0 and `addr_vld` to 0. It also returns the set-A pointer to 0 and the set-B pointer to `SET_LEN` (30), so the first read of each set after reset yields 0 and 30 respectively.
- R2: When `en`=1 at a rising edge, after that edge `addr_vld`=1 and `addr` equals the selected set's pointer value from before the edge (`set_sel`=0 selects set A, `set_sel`=1 selects set B).
- R3: With `count_up`=1, successive enabled reads of one set return addresses that increase by one. The pointer does not restart from its base on each cycle.
- R4: With `count_up`=0, successive enabled reads of one set return addresses that decrease by one.
- R5: Set A wraps inside addresses 0..29: after 29, counting up reads 0 next; after 0, counting down reads 29 next.
- R6: Set B wraps inside addresses 30..59: after 59, counting up reads 30 next; after 30, counting down reads 59 next.
- R7: The pointer of the set that is not selected holds its value. When the selection returns to that set, reading resumes from where it stopped.
- R8: When `en`=0 at a rising edge, after that edge `addr_vld`=0, `addr` keeps its previous value, and neither pointer moves.
- R9: Every address presented with `addr_vld`=1 lies inside the region of the set selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Step enable: present an address and advance the selected pointer |
| set_sel | input | 1 | Set select: 0 = set A (lower region), 1 = set B (upper region) |
| count_up | input | 1 | Direction: 1 = increment, 0 = decrement |
| addr | output | 6 | Registered memory read address |
| addr_vld | output | 1 | High in each cycle in which a fresh address is presented |

## Verification
Every result is due one clock after the edge that samples `en`, `set_sel` and `count_up`. The single output register stage presents the pre-step pointer value, and the pointer has moved by that same edge. The bench changes the inputs on the falling edge, lets exactly one rising edge pass, and compares `addr` and `addr_vld` on the next falling edge with a model that steps two pointers arithmetically, modulo the region length. Resumption after a set switch is checked the same way: the bench model leaves the idle set's pointer untouched, so any drift shows up on the first read after the switch back.

// File: rtl/coef_seq_pkg.sv
`timescale 1ns/1ps
package coef_seq_pkg;

    // Sequencer states: which set, if any, is presenting an address.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_EMIT_A = 2'd1,
        SEQ_EMIT_B = 2'd2
    } seq_state_e;

    // Number of coefficient sets (one select bit picks between them).
    localparam int unsigned SET_CNT = 2;

endpackage

// File: rtl/coef_ptr_bank.sv
`timescale 1ns/1ps
// Holds one address pointer per coefficient set. Each pointer wraps
// inside its own region [g*SET_LEN, g*SET_LEN + SET_LEN - 1].
module coef_ptr_bank
    import coef_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned SET_LEN = 30
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SET_CNT-1:0]               step,
    input  logic                             count_up,
    output logic [SET_CNT-1:0][ADDR_W-1:0]   ptr_q
);

    logic [SET_CNT-1:0][ADDR_W-1:0] ptr_nxt;

    // Per-set wrap logic; the bounds differ per region.
    for (genvar g = 0; g < SET_CNT; g++) begin : g_wrap
        localparam int unsigned  BASE_I = g * SET_LEN;
        localparam int unsigned  LAST_I = BASE_I + SET_LEN - 1;
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_I);
        localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_I);

        always_comb begin
            if (count_up) begin
                if (ptr_q[g] == LAST) begin
                    ptr_nxt[g] = BASE;
                end else begin
                    ptr_nxt[g] = ptr_q[g] + 1'b1;
                end
            end else begin
                if (ptr_q[g] == BASE) begin
                    ptr_nxt[g] = LAST;
                end else begin
                    ptr_nxt[g] = ptr_q[g] - 1'b1;
                end
            end
        end
    end

    // All pointers share one clocked process; only a stepped pointer moves.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < SET_CNT; i++) begin
                ptr_q[i] <= ADDR_W'(i * SET_LEN);
            end
        end else begin
            for (int i = 0; i < SET_CNT; i++) begin
                if (step[i]) begin
                    ptr_q[i] <= ptr_nxt[i];
                end
            end
        end
    end

endmodule

// File: rtl/coef_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer controller: decides the next state, which pointer steps,
// and loads the registered address and valid outputs.
module coef_seq_fsm
    import coef_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic                            set_sel,
    input  logic [SET_CNT-1:0][ADDR_W-1:0]  ptr_q,
    output logic [SET_CNT-1:0]              step,
    output seq_state_e                      state_q,
    output logic [ADDR_W-1:0]               addr_q,
    output logic                            vld_q
);

    seq_state_e state_nxt;

    // Transition decode: every state reacts to the same inputs.
    always_comb begin
        state_nxt = SEQ_IDLE;
        unique case (state_q)
            SEQ_IDLE, SEQ_EMIT_A, SEQ_EMIT_B: begin
                if (en) begin
                    state_nxt = set_sel ? SEQ_EMIT_B : SEQ_EMIT_A;
                end else begin
                    state_nxt = SEQ_IDLE;
                end
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // Step decode from the state being entered.
    always_comb begin
        step = '0;
        unique case (state_nxt)
            SEQ_IDLE:   step = '0;
            SEQ_EMIT_A: step[0] = 1'b1;
            SEQ_EMIT_B: step[1] = 1'b1;
            default:    step = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output registers: present the pre-step pointer of the chosen set.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            unique case (state_nxt)
                SEQ_IDLE: begin
                    vld_q <= 1'b0;
                end
                SEQ_EMIT_A: begin
                    addr_q <= ptr_q[0];
                    vld_q  <= 1'b1;
                end
                SEQ_EMIT_B: begin
                    addr_q <= ptr_q[1];
                    vld_q  <= 1'b1;
                end
                default: begin
                    vld_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/coef_addr_seq.sv
`timescale 1ns/1ps
// Top: two-region coefficient read-address sequencer.
module coef_addr_seq
    import coef_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned SET_LEN = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              set_sel,
    input  logic              count_up,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_vld
);

    localparam int unsigned SPACE = SET_CNT * SET_LEN;

    logic [SET_CNT-1:0][ADDR_W-1:0] ptr_q;
    logic [SET_CNT-1:0]             step;
    seq_state_e                     state_q;

    coef_ptr_bank #(
        .ADDR_W  (ADDR_W),
        .SET_LEN (SET_LEN)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .count_up (count_up),
        .ptr_q    (ptr_q)
    );

    coef_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .set_sel (set_sel),
        .ptr_q   (ptr_q),
        .step    (step),
        .state_q (state_q),
        .addr_q  (addr),
        .vld_q   (addr_vld)
    );

    // Elaboration-time sanity: the whole space must fit the address width.
    if (SPACE > (1 << ADDR_W)) begin : g_bad_cfg
        $error("coef_addr_seq: address width too small for both regions");
    end

endmodule

// File: rtl/coef_addr_seq_chk.sv
`timescale 1ns/1ps
// Property checker attached to the sequencer top.
module coef_addr_seq_chk
    import coef_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned SET_LEN = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              set_sel,
    input logic              count_up,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_vld,
    input logic [ADDR_W-1:0] ptr_a,
    input logic [ADDR_W-1:0] ptr_b,
    input seq_state_e        state
);

    localparam logic [ADDR_W-1:0] A_BASE = '0;
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(SET_LEN - 1);
    localparam logic [ADDR_W-1:0] B_BASE = ADDR_W'(SET_LEN);
    localparam logic [ADDR_W-1:0] B_LAST = ADDR_W'(2 * SET_LEN - 1);

    p_vld_on_en_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> addr_vld);

    p_state_vld_r2: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE) |-> addr_vld);

    p_idle_novld_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !addr_vld);

    p_idle_hold_addr_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr));

    p_a_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !set_sel && count_up && ptr_a != A_LAST) |=> ptr_a == $past(ptr_a) + 1'b1);

    p_b_step_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (en && set_sel && !count_up && ptr_b != B_BASE) |=> ptr_b == $past(ptr_b) - 1'b1);

    p_a_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !set_sel && count_up && ptr_a == A_LAST) |=> ptr_a == A_BASE);

    p_a_wrap_dn_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !set_sel && !count_up && ptr_a == A_BASE) |=> ptr_a == A_LAST);

    p_b_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
        (en && set_sel && count_up && ptr_b == B_LAST) |=> ptr_b == B_BASE);

    p_b_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!en || !set_sel) |=> $stable(ptr_b));

    p_a_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!en || set_sel) |=> $stable(ptr_a));

    p_a_region_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !set_sel) |=> addr <= A_LAST);

    p_b_region_r9: assert property (@(posedge clk) disable iff (rst)
        (en && set_sel) |=> (addr >= B_BASE) && (addr <= B_LAST));

endmodule

bind coef_addr_seq coef_addr_seq_chk #(
    .ADDR_W  (ADDR_W),
    .SET_LEN (SET_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .set_sel  (set_sel),
    .count_up (count_up),
    .addr     (addr),
    .addr_vld (addr_vld),
    .ptr_a    (ptr_q[0]),
    .ptr_b    (ptr_q[1]),
    .state    (state_q)
);

// File: tb/coef_addr_seq_bench.sv
`timescale 1ns/1ps
module coef_addr_seq_bench;

    localparam int ADDR_W  = 6;
    localparam int SET_LEN = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              set_sel = 1'b0;
    logic              count_up = 1'b1;
    logic [ADDR_W-1:0] addr;
    logic              addr_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int  m_ptr [2];
    bit  m_fresh [2];
    int  m_last_sel;
    int  m_addr;

    always #2 clk = ~clk;  // 250 MHz

    coef_addr_seq #(.ADDR_W(ADDR_W), .SET_LEN(SET_LEN)) u_coef_addr_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .set_sel  (set_sel),
        .count_up (count_up),
        .addr     (addr),
        .addr_vld (addr_vld)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_ptr[0] = 0;
        m_ptr[1] = SET_LEN;
        m_fresh[0] = 1;
        m_fresh[1] = 1;
        m_last_sel = -1;
        m_addr = 0;
    endfunction

    // One sequencer cycle: drive at a falling edge, check at the next one.
    task automatic cycle(input bit e, input bit s, input bit up);
        string tag;
        int    base;
        int    exp_addr;
        bit    wrapped;
        en = e;
        set_sel = s;
        count_up = up;
        @(posedge clk);
        @(negedge clk);
        if (!e) begin
            check("R8 valid low", int'(addr_vld), 0);
            check("R8 address held", int'(addr), m_addr);
        end else begin
            base = s ? SET_LEN : 0;
            exp_addr = m_ptr[s];
            wrapped = 0;
            if (m_fresh[s]) tag = "R1 first read";
            else if (m_last_sel != int'(s)) tag = "R7 resume";
            else if (up && exp_addr == base) tag = s ? "R6 wrap up" : "R5 wrap up";
            else if (!up && exp_addr == base + SET_LEN - 1) tag = s ? "R6 wrap down" : "R5 wrap down";
            else tag = up ? "R3 step up" : "R4 step down";
            check("R2 valid high", int'(addr_vld), 1);
            check(tag, int'(addr), exp_addr);
            check("R9 region", int'((addr >= base) && (addr < base + SET_LEN)), 1);
            if (up) m_ptr[s] = base + ((exp_addr - base + 1) % SET_LEN);
            else    m_ptr[s] = base + ((exp_addr - base + SET_LEN - 1) % SET_LEN);
            m_fresh[s] = 0;
            m_last_sel = s;
            m_addr = exp_addr;
            if (wrapped) m_addr = exp_addr;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(addr_vld), 0);
        check("R1 reset address", int'(addr), 0);
        rst = 1'b0;
        @(negedge clk);

        // Full sweeps, each long enough to cross a region boundary twice.
        for (int k = 0; k < 65; k++) cycle(1, 0, 1);
        for (int k = 0; k < 65; k++) cycle(1, 0, 0);
        for (int k = 0; k < 65; k++) cycle(1, 1, 1);
        for (int k = 0; k < 65; k++) cycle(1, 1, 0);

        // Enable gaps: address held, no pointer motion (R8).
        for (int k = 0; k < 5; k++) cycle(0, k[0], k[1]);
        cycle(1, 0, 1);
        cycle(1, 1, 1);

        // Interleaved pattern: set switching and resumption (R7).
        for (int k = 0; k < 8; k++) cycle(1, 0, 1);
        for (int k = 0; k < 8; k++) cycle(1, 1, 0);
        for (int k = 0; k < 4; k++) cycle(1, 0, 1);

        // Pseudo-random mix of enable, select and direction.
        lfsr = 8'hA5;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cycle(lfsr[0] | lfsr[3], lfsr[1], lfsr[2]);
        end

        // Asynchronous reset in mid-run (R1).
        @(negedge clk);
        #1 rst = 1'b1;
        #1;
        check("R1 async reset valid", int'(addr_vld), 0);
        check("R1 async reset address", int'(addr), 0);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        cycle(1, 1, 0);
        cycle(1, 0, 0);
        cycle(1, 0, 0);
        cycle(1, 1, 1);

        summary();
    end

endmodule